// File: doc/BRIEF.md
# Function-Code Bus Address Decoder

This block sits behind a CPU bus with a 24-bit byte address and a 3-bit function code. It routes each access to one of four targets: an internal program ROM, an internal data RAM, an input character port or an output character port. Function-code bit 1 chooses the space. When it is set, the access goes to program space and can only read ROM. When it is clear, the access goes to data space. There, two exact addresses select the device ports and the low 256 bytes select RAM.

Byte, word and long accesses are served from byte-wide storage. Multi-byte values are assembled and split big-endian. An access that fits no permitted target raises a one-cycle bus-error pulse and changes no storage. Read data comes back one cycle after the strobe, qualified by a valid flag. Device behaviour lives outside this block: the decoder only raises the port selects in the strobe cycle, passes size-masked write data and returns the device's read data.

Top module: `fcspace_decoder`

## Requirements
- R1: With function-code bit 1 set, a read is served from ROM and no device select rises. The ROM byte at offset a is (a mod 256) XOR (a >> 8) XOR 0xA5.
- R2: The ROM spans offsets 0x000 to 0xFFF. A program-space access whose last byte lies beyond 0xFFF pulses bus_error and gives no rd_valid.
- R3: Every program-space write pulses bus_error. ROM contents and RAM contents stay unchanged afterwards.
- R4: In data space, address 0x800000 raises in_sel and address 0x400000 raises out_sel, during the strobe cycle. Only exact matches select a port, and the matches are tested before the RAM range. A device read returns that port's read data masked to the access size.
- R5: A data-space write to a device port raises dev_we with its select. dev_wdata carries the low 8, 16 or 32 bits of wdata for byte, word or long.
- R6: Data RAM spans 0x00 to 0xFF. A non-device data access whose last byte lies beyond 0xFF pulses bus_error and leaves RAM unchanged.
- R7: Multi-byte data is big-endian. The byte at the access address holds the most significant bits, for both word and long.
- R8: A successful read gives rd_valid and rdata on the cycle after the strobe. rd_valid and bus_error are each single-cycle pulses and both are low after reset.
- R9: Size codes are 0 for byte, 1 for word and 2 for long. Size code 3 pulses bus_error and selects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| fc | input | 3 | CPU function code; bit 1 selects program space |
| size | input | 2 | 0 byte, 1 word, 2 long, 3 invalid |
| addr | input | 24 | Byte address |
| wdata | input | 32 | Write data, right-aligned |
| in_rdata | input | 32 | Read data from the input port |
| out_rdata | input | 32 | Read data from the output port |
| in_sel | output | 1 | Input port selected this cycle |
| out_sel | output | 1 | Output port selected this cycle |
| dev_we | output | 1 | Selected port is being written |
| dev_wdata | output | 32 | Size-masked write data for the port |
| rd_valid | output | 1 | Read data valid |
| rdata | output | 32 | Read data, right-aligned |
| bus_error | output | 1 | Access rejected |

## Verification
The bench probes the edges of both storage ranges with accesses that straddle them: a long at 0xFFD in ROM and a long at 0xFE in RAM. A decoder that checks only the start address would accept these and wrap or corrupt storage. It sends a write in program space and a device address in program space. A design that decoded the space from the address would write storage or raise a port select. It also tries an address one off a device port and the invalid size code, and it reads words and longs back after writing them at other widths. A reversed or shifted byte order then shows up in rdata.

// File: rtl/fcspace_decoder.sv
module fcspace_decoder #(
  parameter int AW = 24,
  parameter int ROM_AW = 12,
  parameter int RAM_AW = 8,
  parameter logic [AW-1:0] IN_PORT = 24'h800000,
  parameter logic [AW-1:0] OUT_PORT = 24'h400000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [2:0]    fc,
  input  logic [1:0]    size,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic [31:0]   in_rdata,
  input  logic [31:0]   out_rdata,
  output logic          in_sel,
  output logic          out_sel,
  output logic          dev_we,
  output logic [31:0]   dev_wdata,
  output logic          rd_valid,
  output logic [31:0]   rdata,
  output logic          bus_error
);
  localparam int ROM_BYTES = 1 << ROM_AW;
  localparam int RAM_BYTES = 1 << RAM_AW;

  logic [7:0] rom [ROM_BYTES];
  logic [7:0] ram [RAM_BYTES];

  initial begin
    for (int a = 0; a < ROM_BYTES; a++)
      rom[a] = 8'(a) ^ 8'(a >> 8) ^ 8'hA5;
  end

  logic [2:0]  nb;
  logic [31:0] mask;
  always_comb begin
    case (size)
      2'd0: begin nb = 3'd1; mask = 32'h0000_00FF; end
      2'd1: begin nb = 3'd2; mask = 32'h0000_FFFF; end
      2'd2: begin nb = 3'd4; mask = 32'hFFFF_FFFF; end
      default: begin nb = 3'd0; mask = 32'h0; end
    endcase
  end

  wire          size_ok = (size != 2'd3);
  wire          prog    = fc[1];
  wire [AW:0]   last    = {1'b0, addr} + (AW+1)'(nb) - (AW+1)'(1);
  wire          in_hit  = !prog && (addr == IN_PORT);
  wire          out_hit = !prog && (addr == OUT_PORT);
  wire          rom_ok  = prog && !we && (last < (AW+1)'(ROM_BYTES));
  wire          ram_ok  = !prog && !in_hit && !out_hit && (last < (AW+1)'(RAM_BYTES));
  wire          hit_ok  = size_ok && (rom_ok || ram_ok || in_hit || out_hit);

  assign in_sel    = req && size_ok && in_hit;
  assign out_sel   = req && size_ok && out_hit;
  assign dev_we    = (in_sel || out_sel) && we;
  assign dev_wdata = wdata & mask;

  logic [31:0] mem_rd;
  always_comb begin
    mem_rd = 32'h0;
    for (int i = 0; i < 4; i++) begin
      if (3'(i) < nb) begin
        if (prog)
          mem_rd = {mem_rd[23:0], rom[addr[ROM_AW-1:0] + ROM_AW'(i)]};
        else
          mem_rd = {mem_rd[23:0], ram[addr[RAM_AW-1:0] + RAM_AW'(i)]};
      end
    end
  end

  wire [31:0] rd_next = in_hit  ? (in_rdata & mask)  :
                        out_hit ? (out_rdata & mask) : mem_rd;
  wire        rd_ok   = req && !we && hit_ok;
  wire        ram_wr  = req && we && hit_ok && ram_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      bus_error <= 1'b0;
      rdata     <= 32'h0;
    end else begin
      rd_valid  <= rd_ok;
      bus_error <= req && !hit_ok;
      if (rd_ok) rdata <= rd_next;
    end
  end

  always_ff @(posedge clk) begin
    if (ram_wr) begin
      for (int i = 0; i < 4; i++)
        if (3'(i) < nb)
          ram[addr[RAM_AW-1:0] + RAM_AW'(i)] <= 8'(wdata >> (8 * (32'(nb) - 1 - i)));
    end
  end

  AST_PROG_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fc[1]) |-> (!in_sel && !out_sel)); // R1
  AST_PROG_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && fc[1]) |=> bus_error); // R3
  AST_DEV_WE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    dev_we |-> (in_sel || out_sel)); // R5
  AST_SIZE3_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req && size == 2'd3) |=> (bus_error && !rd_valid)); // R9
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> (rd_valid != bus_error)); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!rd_valid && !bus_error)); // R8
endmodule

// File: tb/test_fcspace_decoder.sv
module test_fcspace_decoder;
  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [2:0] fc = 0;
  logic [1:0] size = 0;
  logic [23:0] addr = 0;
  logic [31:0] wdata = 0, in_rdata = 0, out_rdata = 0;
  logic in_sel, out_sel, dev_we, rd_valid, bus_error;
  logic [31:0] dev_wdata, rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fcspace_decoder i_fcspace_decoder (.*);

  logic s_in, s_out, s_dwe, s_val, s_err;
  logic [31:0] s_dwd, s_rd;

  function automatic logic [7:0] rom_exp(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'hA5;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(logic [2:0] f, logic w, logic [1:0] sz, logic [23:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; fc = f; size = sz; addr = a; wdata = d;
    #1;
    s_in = in_sel; s_out = out_sel; s_dwe = dev_we; s_dwd = dev_wdata;
    @(negedge clk);
    req = 0; we = 0;
    s_val = rd_valid; s_err = bus_error; s_rd = rdata;
  endtask

  task automatic rd_chk(logic [2:0] f, logic [1:0] sz, logic [23:0] a, logic [31:0] exp, string tag);
    acc(f, 0, sz, a, 0);
    chk(s_val && !s_err && s_rd == exp, tag, s_rd, exp);
  endtask

  task automatic err_chk(logic [2:0] f, logic w, logic [1:0] sz, logic [23:0] a, string tag);
    acc(f, w, sz, a, 32'hFFFF_FFFF);
    chk(s_err && !s_val && !s_in && !s_out, tag, {s_err, s_val, s_in, s_out}, 4'b1000);
  endtask

  task automatic t_reset;
    chk(!rd_valid && !bus_error, "R8 reset", {rd_valid, bus_error}, 0);
  endtask

  task automatic t_rom;
    rd_chk(3'd6, 2, 24'h120, {rom_exp('h120), rom_exp('h121), rom_exp('h122), rom_exp('h123)}, "R1 rom long");
    chk(!s_in && !s_out, "R1 no sel", {s_in, s_out}, 0);
    rd_chk(3'd2, 1, 24'hFFE, {16'h0, rom_exp('hFFE), rom_exp('hFFF)}, "R2 rom word at top");
    rd_chk(3'd2, 0, 24'hFFF, {24'h0, rom_exp('hFFF)}, "R2 rom last byte");
    err_chk(3'd2, 0, 2, 24'hFFD, "R2 rom long straddle");
    err_chk(3'd2, 0, 0, 24'h1000, "R2 rom past end");
    err_chk(3'd2, 0, 0, 24'h800000, "R1 device addr in program space");
  endtask

  task automatic t_ram;
    acc(3'd1, 1, 2, 24'h40, 32'h1122_3344);
    chk(!s_err && !s_val, "R7 long write", {s_err, s_val}, 0);
    rd_chk(3'd1, 0, 24'h40, 32'h11, "R7 msb first");
    rd_chk(3'd1, 0, 24'h43, 32'h44, "R7 lsb last");
    rd_chk(3'd1, 1, 24'h41, 32'h2233, "R7 mid word");
    acc(3'd1, 1, 1, 24'hFE, 32'h5555_ABCD);
    rd_chk(3'd1, 1, 24'hFE, 32'hABCD, "R6 word at top");
    err_chk(3'd1, 1, 2, 24'hFE, "R6 long straddle write");
    rd_chk(3'd1, 1, 24'hFE, 32'hABCD, "R6 ram unchanged");
    err_chk(3'd1, 0, 0, 24'h100, "R6 byte past end");
  endtask

  task automatic t_prog_write;
    acc(3'd1, 1, 0, 24'h10, 32'h5A);
    err_chk(3'd2, 1, 0, 24'h10, "R3 program write");
    rd_chk(3'd2, 0, 24'h10, {24'h0, rom_exp('h10)}, "R3 rom unchanged");
    rd_chk(3'd1, 0, 24'h10, 32'h5A, "R3 ram unchanged");
  endtask

  task automatic t_dev;
    in_rdata = 32'h1234_56C3; out_rdata = 32'h8765_4321;
    acc(3'd1, 0, 0, 24'h800000, 0);
    chk(s_in && !s_out && s_val && s_rd == 32'hC3, "R4 input read byte", s_rd, 32'hC3);
    acc(3'd5, 0, 1, 24'h400000, 0);
    chk(s_out && !s_in && s_val && s_rd == 32'h4321, "R4 output read word", s_rd, 32'h4321);
    acc(3'd1, 1, 1, 24'h400000, 32'hDEAD_BEEF);
    chk(s_out && s_dwe && !s_err && s_dwd == 32'hBEEF, "R5 word to output", s_dwd, 32'hBEEF);
    acc(3'd1, 1, 0, 24'h800000, 32'hDEAD_BEEF);
    chk(s_in && s_dwe && s_dwd == 32'hEF, "R5 byte to input", s_dwd, 32'hEF);
    acc(3'd1, 1, 2, 24'h400000, 32'hDEAD_BEEF);
    chk(s_dwe && s_dwd == 32'hDEAD_BEEF, "R5 long to output", s_dwd, 32'hDEAD_BEEF);
    err_chk(3'd1, 0, 0, 24'h800001, "R4 near miss");
  endtask

  task automatic t_size3;
    err_chk(3'd1, 0, 3, 24'h0, "R9 invalid size ram");
    err_chk(3'd1, 1, 3, 24'h800000, "R9 invalid size device");
  endtask

  task automatic t_pulse;
    rd_chk(3'd1, 0, 24'h40, 32'h11, "R8 read");
    @(negedge clk);
    chk(!rd_valid, "R8 valid one cycle", rd_valid, 0);
    err_chk(3'd1, 0, 0, 24'h200, "R8 error");
    @(negedge clk);
    chk(!bus_error, "R8 error one cycle", bus_error, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_rom();
    t_ram();
    t_prog_write();
    t_dev();
    t_size3();
    t_pulse();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule